// File: doc/BRIEF.md
# Shared Prescaler Tick Generator

This block turns one free-running divider into count-enable strobes for several timer channels. A 10-bit counter advances on every system clock cycle. Four taps are taken from it, at divide ratios of 8, 64, 256 and 1024. Each channel owns a 3-bit select code. The code picks one of these sources: nothing, every system clock cycle, one of the four taps, or a pre-conditioned edge pulse from that channel's external pin. The result is a registered strobe, one system clock cycle wide, that the channel's timer counter uses as its count enable.

The divider is shared. Because of that, its phase is common to all channels, and a select code never restarts it. A channel switched onto a tap therefore waits for the shared counter to reach the next tap point before its first strobe. A synchronous prescaler-reset input returns the counter to zero. This re-aligns every channel that is using a tap. The timer counters and the pin synchronizer are outside this block. Edges arrive as per-channel single-cycle rise and fall pulses.

Top module: `tick_gen`

## Requirements
- R1: Select code 1 makes the channel's enable high on every cycle that follows a cycle in which code 1 was applied.
- R2: Select code 0 keeps the channel's enable low on the following cycle, whatever the edge pulse inputs do.
- R3: Codes 2, 3, 4 and 5 select divisors 8, 64, 256 and 1024. After a prescaler reset sampled at edge E0, a channel held on divisor N strobes exactly at edges E0+kN for k ≥ 1, and at no other edge.
- R4: The shared counter advances by one on every edge without prescaler reset, and a channel's select code never restarts or gates it. A channel moved from code 0 to divisor N therefore strobes first between 1 and N edges later, at the shared tap point.
- R5: Prescaler reset clears the shared counter to zero. The reset edge itself produces no tap strobe for any divisor, including when the counter was at a tap point.
- R6: Code 6 passes the channel's falling-edge pulse and code 7 passes its rising-edge pulse, one cycle later. The other pulse input is ignored in both codes.
- R7: Each enable is registered. It reflects the select code and source value seen at the previous edge, and it lasts one cycle per event.
- R8: Channels select independently. Different codes on different channels give each channel its own strobe pattern from the same counter.
- R9: While the asynchronous active-low reset is asserted, all enables are low and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc_rst | input | 1 | Synchronous clear of the shared prescaler counter |
| sel_i | input | 3*NUM_CH | Per-channel select codes; channel i uses bits [3i+2:3i] |
| ext_rise_i | input | NUM_CH | Per-channel rising-edge pulse from pin conditioning |
| ext_fall_i | input | NUM_CH | Per-channel falling-edge pulse from pin conditioning |
| cnt_en_o | output | NUM_CH | Per-channel registered one-cycle count enable |

## Verification
A wrong count in the shared divider shows up at the ports as strobes at the wrong distance from a prescaler reset. With divisor 8, the error is visible within eight edges. An error in a high bit of the counter shows only on the 256 or 1024 taps, so the bench keeps those taps running for more than two full periods. A wrong tap decode, or a wrong select decode in a channel, appears as a misplaced or missing strobe on the very next edge. Edge codes and direct clocking are therefore checked cycle by cycle.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int NUM_TAPS = 4;
    localparam int SEL_W    = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_OFF   = 3'd0,
        SEL_SYS   = 3'd1,
        SEL_D8    = 3'd2,
        SEL_D64   = 3'd3,
        SEL_D256  = 3'd4,
        SEL_D1024 = 3'd5,
        SEL_FALL  = 3'd6,
        SEL_RISE  = 3'd7
    } sel_e;

    // number of low counter bits that define the period of tap t
    function automatic int tap_bits(input int t);
        case (t)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import tick_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                psc_rst,
    output logic [CNT_W-1:0]    cnt_o,
    output logic [NUM_TAPS-1:0] tap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } psc_state_t;

    psc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (psc_rst) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A tap fires when its low field is about to roll over to zero.
    // A prescaler clear takes precedence, so that edge produces no roll-over.
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        localparam int TB = tap_bits(t);
        assign tap_o[t] = (&st_q.cnt[TB-1:0]) && !psc_rst;
    end

    assign cnt_o = st_q.cnt;

    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !psc_rst |=> st_q.cnt == $past(st_q.cnt) + 1'b1); // R4
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        psc_rst |=> st_q.cnt == '0); // R5
    AST_NO_TAP_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        psc_rst |-> tap_o == '0); // R5

endmodule

// File: rtl/tick_chan_sel.sv
module tick_chan_sel
    import tick_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [NUM_TAPS-1:0] taps_i,
    input  logic                rise_i,
    input  logic                fall_i,
    output logic                en_o
);

    typedef struct packed {
        logic en;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (sel_e'(sel_i))
            SEL_OFF:   st_d.en = 1'b0;
            SEL_SYS:   st_d.en = 1'b1;
            SEL_D8:    st_d.en = taps_i[0];
            SEL_D64:   st_d.en = taps_i[1];
            SEL_D256:  st_d.en = taps_i[2];
            SEL_D1024: st_d.en = taps_i[3];
            SEL_FALL:  st_d.en = fall_i;
            SEL_RISE:  st_d.en = rise_i;
            default:   st_d.en = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i == SEL_OFF |=> !en_o); // R2
    AST_SYS_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i == SEL_SYS |=> en_o); // R1
    AST_RISE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i == SEL_RISE |=> en_o == $past(rise_i)); // R6
    AST_FALL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i == SEL_FALL |=> en_o == $past(fall_i)); // R6

endmodule

// File: rtl/tick_gen.sv
module tick_gen
    import tick_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    psc_rst,
    input  logic [NUM_CH*SEL_W-1:0] sel_i,
    input  logic [NUM_CH-1:0]       ext_rise_i,
    input  logic [NUM_CH-1:0]       ext_fall_i,
    output logic [NUM_CH-1:0]       cnt_en_o
);

    logic [CNT_W-1:0]    cnt;
    logic [NUM_TAPS-1:0] taps;

    tick_prescaler #(.CNT_W(CNT_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .psc_rst (psc_rst),
        .cnt_o   (cnt),
        .tap_o   (taps)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tick_chan_sel u_sel (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel_i  (sel_i[c*SEL_W +: SEL_W]),
            .taps_i (taps),
            .rise_i (ext_rise_i[c]),
            .fall_i (ext_fall_i[c]),
            .en_o   (cnt_en_o[c])
        );

        AST_D8_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_i[c*SEL_W +: SEL_W] == SEL_D8) |=> (!cnt_en_o[c] || cnt[2:0] == 3'd0)); // R3
        AST_D1024_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_i[c*SEL_W +: SEL_W] == SEL_D1024) |=> (!cnt_en_o[c] || cnt[9:0] == 10'd0)); // R3
    end

endmodule

// File: tb/tb_tick_gen.sv
module tb_tick_gen;

    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           psc_rst;
    logic [3*NCH-1:0] sel;
    logic [NCH-1:0] rise, fall;
    logic [NCH-1:0] en;

    int total = 0;
    int failed = 0;

    always #2 clk = ~clk;

    tick_gen #(.NUM_CH(NCH), .CNT_W(10)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .psc_rst    (psc_rst),
        .sel_i      (sel),
        .ext_rise_i (rise),
        .ext_fall_i (fall),
        .cnt_en_o   (en)
    );

    // {sel[2:0], rise, fall, expected enable one edge later} for channel 0
    localparam logic [5:0] VEC [12] = '{
        {3'd1, 1'b0, 1'b0, 1'b1},
        {3'd0, 1'b1, 1'b1, 1'b0},
        {3'd7, 1'b1, 1'b0, 1'b1},
        {3'd7, 1'b0, 1'b1, 1'b0},
        {3'd7, 1'b0, 1'b0, 1'b0},
        {3'd6, 1'b0, 1'b1, 1'b1},
        {3'd6, 1'b1, 1'b0, 1'b0},
        {3'd6, 1'b1, 1'b1, 1'b1},
        {3'd7, 1'b1, 1'b1, 1'b1},
        {3'd0, 1'b1, 1'b1, 1'b0},
        {3'd1, 1'b0, 1'b1, 1'b1},
        {3'd6, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // prescaler reset applied at the next edge (E0); returns after E0
    task automatic sync_psc();
        psc_rst = 1'b1;
        tick();
        psc_rst = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        total++;
        failed++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        int e0, e1, e2, first;
        rst_n = 1'b0; psc_rst = 1'b0; sel = '0; rise = '0; fall = '0;
        sel[2:0] = 3'd1;
        repeat (3) tick();
        check(en == '0, "R9 enables low in reset", en, 0);
        rst_n = 1'b1;
        sel = '0;
        tick();

        // R6 R7 R1 R2: table walk on channel 0
        foreach (VEC[i]) begin
            sel[2:0] = VEC[i][5:3];
            rise[0]  = VEC[i][2];
            fall[0]  = VEC[i][1];
            tick();
            check(en[0] == VEC[i][0], $sformatf("R6/R7 vector %0d", i), en[0], VEC[i][0]);
        end
        rise = '0; fall = '0;

        // R3 R8 R1: divisors 8 and 64 against a direct channel
        sel = {3'd1, 3'd3, 3'd2};
        sync_psc();
        check(en[1:0] == 2'b00, "R5 no strobe on reset edge", en[1:0], 0);
        e0 = 0; e1 = 0; e2 = 0;
        for (int k = 1; k <= 256; k++) begin
            tick();
            if (en[0] != (k % 8 == 0)) e0++;
            if (en[1] != (k % 64 == 0)) e1++;
            if (en[2] != 1'b1) e2++;
        end
        check(e0 == 0, "R3 divisor 8 pattern", e0, 0);
        check(e1 == 0, "R3 R8 divisor 64 pattern", e1, 0);
        check(e2 == 0, "R1 direct channel every cycle", e2, 0);

        // R3 R2: divisors 256 and 1024, channel 2 stopped
        sel = {3'd0, 3'd5, 3'd4};
        rise = '1; fall = '1;
        sync_psc();
        e0 = 0; e1 = 0; e2 = 0;
        for (int k = 1; k <= 2100; k++) begin
            tick();
            if (en[0] != (k % 256 == 0)) e0++;
            if (en[1] != (k % 1024 == 0)) e1++;
            if (en[2] != 1'b0) e2++;
        end
        rise = '0; fall = '0;
        check(e0 == 0, "R3 divisor 256 pattern", e0, 0);
        check(e1 == 0, "R3 divisor 1024 pattern", e1, 0);
        check(e2 == 0, "R2 stopped channel quiet", e2, 0);

        // R4: late switch onto divisor 8 keeps shared phase
        sel = {3'd0, 3'd3, 3'd0};
        sync_psc();
        first = 0; e1 = 0;
        for (int k = 1; k <= 40; k++) begin
            tick();
            if (en[0] && first == 0) first = k;
            if (en[1]) e1++;
            if (k == 12) sel[2:0] = 3'd2;
        end
        check(first == 16, "R4 first strobe at shared tap point", first, 16);
        check(first - 12 >= 1 && first - 12 <= 8, "R4 first-strobe latency within 1..N", first - 12, 4);
        check(e1 == 0, "R4 divisor 64 undisturbed", e1, 0);

        // R5: reset exactly at a tap point suppresses that strobe and restarts phase
        sel = {3'd0, 3'd0, 3'd2};
        sync_psc();
        for (int k = 1; k <= 7; k++) tick();
        sync_psc();
        check(en[0] == 1'b0, "R5 tap suppressed on reset edge", en[0], 0);
        e0 = 0;
        for (int j = 1; j <= 16; j++) begin
            tick();
            if (en[0] != (j % 8 == 0)) e0++;
        end
        check(e0 == 0, "R5 phase restarted after reset", e0, 0);

        // R7: one-cycle strobe width on isolated rising pulse
        sel = {3'd0, 3'd0, 3'd7};
        rise[0] = 1'b1;
        tick();
        rise[0] = 1'b0;
        check(en[0] == 1'b1, "R7 strobe present", en[0], 1);
        tick();
        check(en[0] == 1'b0, "R7 strobe lasts one cycle", en[0], 0);

        // R9: asynchronous reset clears enables mid-run
        sel = {3'd1, 3'd1, 3'd1};
        tick();
        rst_n = 1'b0;
        #1;
        check(en == '0, "R9 reset clears enables", en, 0);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule